// File: doc/BRIEF.md
# Serial Link Fault Monitor

This block decides whether the serial stream on the receive side is healthy enough to trust. It combines four status levels from the analog side and the transmit side with two checks of its own. The first check measures the rate of the recovered clock against a reference. The second checks that the received bits change often enough. The result appears on a single fault pin in the receive clock domain. The pin is high while any condition is unmet and low only when all of them hold together.

The same block also picks which serial stream feeds the recovery path: line A, line B, or the local loopback from the transmitter. It publishes its choice as a two-bit code. A change of stream, or of the expected rate band, throws away the frequency measurement in progress. The link then reads as faulty until one complete measurement window has passed on the new setting.

The block runs entirely on the recovered clock `rx_clk`, one received bit per cycle. The reference is delivered as a level that toggles once per reference period. Each toggle edge counts as one reference tick.

Top module: `link_fault_mon`

## Requirements
- R1: `link_fault` is low only when all of these hold: `amp_ok` high, `carrier_ok` high, `bist_on` low, `tx_halt` low, the run-length check passes and the frequency check passes. In every other case it is high.
- R2: The frequency check counts `rx_clk` cycles across `WIN_REF` reference ticks. It passes when the count lies within E ± floor(E·`PPM_TOL`/1 000 000) inclusive, where E = `WIN_REF` × the ratio of the active band.
- R3: The active band code is {`spd_sel`, effective range}. Codes 00, 01, 10 and 11 select `RATIO_B0`, `RATIO_B1`, `RATIO_B2` and `RATIO_B3` respectively.
- R4: When `spd_sel` is low and `fifo_bypass` is high, `rng_sel` has no effect and the range is taken as 0. When `spd_sel` is high, `fifo_bypass` has no effect.
- R5: `path_sel` encodes the chosen stream as 00 for line A, 01 for line B and 10 for loopback. `loop_en` high selects loopback whatever `line_b_sel` is. The code follows the inputs one `rx_clk` edge later.
- R6: A run of more than `MAX_RUN` identical consecutive bits on `rx_bit` raises the fault. Runs of up to `MAX_RUN` bits do not.
- R7: A change of `path_sel` or of the band restarts the frequency measurement. The fault is high from the following edge until a full window has passed on the new setting.
- R8: If reference ticks stop, the fault rises once the cycle count passes the upper bound. The block does not wait for `WIN_REF` ticks before reporting it.
- R9: The four status inputs pass through two synchronizing flops. A change on one of them shows on `link_fault` at the third `rx_clk` rising edge after it.
- R10: `link_fault` changes only on `rx_clk` rising edges and holds its value while `rx_clk` is stopped.
- R11: While `rst_n` is low, `link_fault` is high and `path_sel` is 00. After reset, the fault stays high until the first full window passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered bit clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_b_sel | input | 1 | Selects line B instead of line A |
| loop_en | input | 1 | Selects the local loopback stream, overriding `line_b_sel` |
| spd_sel | input | 1 | Speed selection, upper bit of the band code |
| rng_sel | input | 1 | Range selection, lower bit of the band code |
| fifo_bypass | input | 1 | High when the transmit and receive FIFOs are bypassed |
| amp_ok | input | 1 | Asynchronous: signal amplitude adequate |
| carrier_ok | input | 1 | Asynchronous: carrier present |
| bist_on | input | 1 | Asynchronous: transmitter self-test active |
| tx_halt | input | 1 | Asynchronous: transmit halt requested |
| ref_tog | input | 1 | Reference level toggling once per reference period |
| rx_bit | input | 1 | Received bit, one per `rx_clk` cycle |
| path_sel | output | 2 | Stream selection code |
| link_fault | output | 1 | Link fault indicator, high when the link is not valid |

## Verification
On every cycle the assertions check several relations. A cleared fault must follow a passing frequency result. A long bit run or a change of stream must force the fault on the next edge. The frequency result may rise only on a reference tick. The window counter may never run more than one cycle past its upper bound. Loopback must win the selection.

Other behaviours can only be shown by the bench's scenarios. These are:
- the exact inclusive ppm edges on both sides;
- the band table, including the ignored range input;
- the three-edge synchronizer latency;
- holding the pin while the clock is stopped.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  typedef enum logic [1:0] {
    SEL_LINE_A = 2'b00,
    SEL_LINE_B = 2'b01,
    SEL_LOOP   = 2'b10
  } path_sel_e;

  localparam int NUM_BANDS = 4;

  function automatic longint lfm_max4(input longint a, input longint b,
                                      input longint c, input longint d);
    longint m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic longint lfm_tol(input longint expect_cnt, input longint ppm);
    return (expect_cnt * ppm) / 64'sd1000000;
  endfunction

endpackage

// File: rtl/lfm_sync.sv
module lfm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/lfm_run_check.sv
module lfm_run_check #(
  parameter int MAX_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic dens_ok
);
  localparam int RW = $clog2(MAX_RUN + 2) + 1;
  localparam logic [RW-1:0] RUN_LIM = RW'(MAX_RUN);

  logic          prev_q, prev_d;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    prev_d = bit_in;
    run_d  = run_q;
    if (bit_in != prev_q) begin
      run_d = RW'(1);
    end else if (run_q <= RUN_LIM) begin
      run_d = run_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= RW'(1);
    end else begin
      prev_q <= prev_d;
      run_q  <= run_d;
    end
  end

  assign dens_ok = (run_q <= RUN_LIM);
endmodule

// File: rtl/lfm_path_sel.sv
module lfm_path_sel
  import lfm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_b_sel,
  input  logic      loop_en,
  output path_sel_e sel_q,
  output logic      sel_chg
);
  path_sel_e sel_d;

  always_comb begin
    if (loop_en)         sel_d = SEL_LOOP;
    else if (line_b_sel) sel_d = SEL_LINE_B;
    else                 sel_d = SEL_LINE_A;
    sel_chg = (sel_d != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_LINE_A;
    else        sel_q <= sel_d;
  end

  // R5: loopback request wins over line choice on the next edge
  p_loop_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (sel_q == SEL_LOOP));
endmodule

// File: rtl/lfm_freq_window.sv
module lfm_freq_window
  import lfm_pkg::*;
#(
  parameter int WIN_REF  = 2500,
  parameter int PPM_TOL  = 400,
  parameter int RATIO_B0 = 4,
  parameter int RATIO_B1 = 8,
  parameter int RATIO_B2 = 20,
  parameter int RATIO_B3 = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_lvl,
  input  logic [1:0] band,
  input  logic       sel_chg,
  output logic       freq_ok
);
  localparam longint RMAX = lfm_max4(RATIO_B0, RATIO_B1, RATIO_B2, RATIO_B3);
  localparam longint CMAX = longint'(WIN_REF) * RMAX * 2 + 4;
  localparam int     CW   = $clog2(CMAX + 1);
  localparam int     TW   = $clog2(WIN_REF + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(WIN_REF - 1);

  function automatic longint ratio_of(input int b);
    case (b)
      0:       return longint'(RATIO_B0);
      1:       return longint'(RATIO_B1);
      2:       return longint'(RATIO_B2);
      default: return longint'(RATIO_B3);
    endcase
  endfunction

  logic [CW-1:0] lo_b [NUM_BANDS];
  logic [CW-1:0] hi_b [NUM_BANDS];

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam longint EXP_CNT = longint'(WIN_REF) * ratio_of(b);
    localparam longint TOL_CNT = lfm_tol(EXP_CNT, longint'(PPM_TOL));
    assign lo_b[b] = CW'(EXP_CNT - TOL_CNT);
    assign hi_b[b] = CW'(EXP_CNT + TOL_CNT);
  end

  logic          ref_prev_q;
  logic          ref_tick;
  logic [1:0]    band_q;
  logic          primed_q, primed_d;
  logic [TW-1:0] tick_q, tick_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          ok_q, ok_d;
  logic [CW-1:0] lo_sel, hi_sel;
  logic          restart;

  assign ref_tick = ref_lvl ^ ref_prev_q;
  assign lo_sel   = lo_b[band_q];
  assign hi_sel   = hi_b[band_q];
  assign restart  = sel_chg | (band != band_q);

  always_comb begin
    primed_d = primed_q;
    tick_d   = tick_q;
    cyc_d    = cyc_q;
    ok_d     = ok_q;
    if (restart) begin
      primed_d = 1'b0;
      ok_d     = 1'b0;
      tick_d   = '0;
      cyc_d    = '0;
    end else if (!primed_q) begin
      if (ref_tick) begin
        primed_d = 1'b1;
        tick_d   = '0;
        cyc_d    = CW'(1);
      end
    end else if (ref_tick && (tick_q == LAST_TICK)) begin
      ok_d   = (cyc_q >= lo_sel) && (cyc_q <= hi_sel);
      tick_d = '0;
      cyc_d  = CW'(1);
    end else if (cyc_q > hi_sel) begin
      ok_d     = 1'b0;
      primed_d = 1'b0;
      tick_d   = '0;
      cyc_d    = '0;
    end else begin
      cyc_d = cyc_q + CW'(1);
      if (ref_tick) tick_d = tick_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
      band_q     <= 2'b00;
      primed_q   <= 1'b0;
      tick_q     <= '0;
      cyc_q      <= '0;
      ok_q       <= 1'b0;
    end else begin
      ref_prev_q <= ref_lvl;
      band_q     <= band;
      primed_q   <= primed_d;
      tick_q     <= tick_d;
      cyc_q      <= cyc_d;
      ok_q       <= ok_d;
    end
  end

  assign freq_ok = ok_q;

  // R2: a passing verdict only appears at a window-closing reference tick
  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(ref_tick));

  // R7: a restart request clears the verdict on the next edge
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ok_q);

  // R8: a missing reference never lets the count run beyond one past the bound
  p_cyc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q <= hi_sel) || (cyc_q == hi_sel + CW'(1)));
endmodule

// File: rtl/link_fault_mon.sv
module link_fault_mon
  import lfm_pkg::*;
#(
  parameter int WIN_REF  = 2500,
  parameter int PPM_TOL  = 400,
  parameter int RATIO_B0 = 4,
  parameter int RATIO_B1 = 8,
  parameter int RATIO_B2 = 20,
  parameter int RATIO_B3 = 40,
  parameter int MAX_RUN  = 5
) (
  input  logic       rx_clk,
  input  logic       rst_n,
  input  logic       line_b_sel,
  input  logic       loop_en,
  input  logic       spd_sel,
  input  logic       rng_sel,
  input  logic       fifo_bypass,
  input  logic       amp_ok,
  input  logic       carrier_ok,
  input  logic       bist_on,
  input  logic       tx_halt,
  input  logic       ref_tog,
  input  logic       rx_bit,
  output logic [1:0] path_sel,
  output logic       link_fault
);
  localparam int NST = 4;

  // reset: asserted asynchronously, released after two rx_clk edges
  logic [1:0] rst_q;
  logic       rst_i_n;
  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  // status synchronizers
  logic [NST-1:0] st_raw, st_s;
  assign st_raw = {amp_ok, carrier_ok, bist_on, tx_halt};

  lfm_sync #(.W(NST)) u_st_sync (
    .clk   (rx_clk),
    .rst_n (rst_i_n),
    .d     (st_raw),
    .q     (st_s)
  );

  logic ref_s;
  lfm_sync #(.W(1)) u_ref_sync (
    .clk   (rx_clk),
    .rst_n (rst_i_n),
    .d     (ref_tog),
    .q     (ref_s)
  );

  // stream selection
  path_sel_e sel_q;
  logic      sel_chg;
  lfm_path_sel u_sel (
    .clk        (rx_clk),
    .rst_n      (rst_i_n),
    .line_b_sel (line_b_sel),
    .loop_en    (loop_en),
    .sel_q      (sel_q),
    .sel_chg    (sel_chg)
  );
  assign path_sel = sel_q;

  // band decode: range forced low for low speed with FIFOs bypassed
  logic       rng_eff;
  logic [1:0] band;
  assign rng_eff = (!spd_sel && fifo_bypass) ? 1'b0 : rng_sel;
  assign band    = {spd_sel, rng_eff};

  logic freq_ok;
  lfm_freq_window #(
    .WIN_REF  (WIN_REF),
    .PPM_TOL  (PPM_TOL),
    .RATIO_B0 (RATIO_B0),
    .RATIO_B1 (RATIO_B1),
    .RATIO_B2 (RATIO_B2),
    .RATIO_B3 (RATIO_B3)
  ) u_freq (
    .clk     (rx_clk),
    .rst_n   (rst_i_n),
    .ref_lvl (ref_s),
    .band    (band),
    .sel_chg (sel_chg),
    .freq_ok (freq_ok)
  );

  logic dens_ok;
  lfm_run_check #(.MAX_RUN(MAX_RUN)) u_run (
    .clk     (rx_clk),
    .rst_n   (rst_i_n),
    .bit_in  (rx_bit),
    .dens_ok (dens_ok)
  );

  // combine and register the indicator
  logic st_good, link_ok, fault_d;
  always_comb begin
    st_good = st_s[3] & st_s[2] & ~st_s[1] & ~st_s[0];
    link_ok = st_good & dens_ok & freq_ok;
    fault_d = ~link_ok;
  end

  always_ff @(posedge rx_clk or negedge rst_i_n) begin
    if (!rst_i_n) link_fault <= 1'b1;
    else          link_fault <= fault_d;
  end

  // R1: a clear indicator requires a passing frequency verdict one edge before
  p_clear_needs_freq_r1: assert property (@(posedge rx_clk) disable iff (!rst_i_n)
    !link_fault |-> $past(freq_ok));

  // R6: an over-long bit run forces the fault on the next edge
  p_density_fault_r6: assert property (@(posedge rx_clk) disable iff (!rst_i_n)
    !dens_ok |=> link_fault);

  // R7: a new stream code is followed by a fault
  p_sel_change_fault_r7: assert property (@(posedge rx_clk) disable iff (!rst_i_n)
    (path_sel != $past(path_sel)) |=> link_fault);
endmodule

// File: tb/link_fault_mon_tb.sv
module link_fault_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 250;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n, line_b_sel, loop_en, spd_sel, rng_sel, fifo_bypass;
  logic amp_ok, carrier_ok, bist_on, tx_halt, ref_tog, rx_bit;
  logic [1:0] path_sel;
  logic link_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference generator controls: base gap, K adjusted intervals per period WIN, shorter if dn
  int  g_gap = 4;
  int  g_k   = 0;
  bit  g_dn  = 0;
  bit  ref_stall = 0;
  int  bit_run = 1; // 0 holds rx_bit constant

  link_fault_mon #(
    .WIN_REF(WIN), .PPM_TOL(4000),
    .RATIO_B0(4), .RATIO_B1(6), .RATIO_B2(8), .RATIO_B3(10),
    .MAX_RUN(5)
  ) dut_i (
    .rx_clk(clk), .rst_n(rst_n), .line_b_sel(line_b_sel), .loop_en(loop_en),
    .spd_sel(spd_sel), .rng_sel(rng_sel), .fifo_bypass(fifo_bypass),
    .amp_ok(amp_ok), .carrier_ok(carrier_ok), .bist_on(bist_on), .tx_halt(tx_halt),
    .ref_tog(ref_tog), .rx_bit(rx_bit), .path_sel(path_sel), .link_fault(link_fault)
  );

  initial begin
    forever begin
      #(CLK_PERIOD/2);
      if (clk_run) clk = ~clk;
    end
  end

  initial begin
    int cnt, idx, gap;
    ref_tog = 1'b0;
    cnt = 0; idx = 0; gap = 4;
    forever begin
      @(negedge clk);
      if (!ref_stall) begin
        cnt++;
        if (cnt >= gap) begin
          ref_tog = ~ref_tog;
          cnt = 0;
          idx = (idx + 1) % WIN;
          gap = g_gap + ((idx < g_k) ? (g_dn ? -1 : 1) : 0);
        end
      end
    end
  end

  initial begin
    int bc;
    rx_bit = 1'b0;
    bc = 0;
    forever begin
      @(negedge clk);
      if (bit_run == 0) bc = 0;
      else begin
        bc++;
        if (bc >= bit_run) begin
          rx_bit = ~rx_bit;
          bc = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic spd; logic rng; logic byp;
    logic [3:0] gap; logic [3:0] k; logic dn;
    logic amp; logic car; logic bist; logic halt;
    logic fault;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,4'd4, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R2 nominal 1000
    '{1'b0,1'b0,1'b0,4'd4, 4'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R2 1004 upper edge
    '{1'b0,1'b0,1'b0,4'd4, 4'd5,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1}, // R2 1005 out
    '{1'b0,1'b0,1'b0,4'd4, 4'd4,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0}, // R2 996 lower edge
    '{1'b0,1'b0,1'b0,4'd4, 4'd5,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1}, // R2 995 out
    '{1'b0,1'b1,1'b0,4'd6, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R3 band 01
    '{1'b0,1'b1,1'b0,4'd4, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1}, // R3 band 01 wrong rate
    '{1'b0,1'b1,1'b1,4'd6, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1}, // R4 range ignored
    '{1'b0,1'b1,1'b1,4'd4, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R4 treated as band 00
    '{1'b1,1'b0,1'b0,4'd8, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R3 band 10
    '{1'b1,1'b1,1'b1,4'd10,4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R4 bypass no effect at high speed
    '{1'b1,1'b1,1'b1,4'd8, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1}, // R3 band 11 wrong rate
    '{1'b0,1'b0,1'b0,4'd4, 4'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1}, // R1 amplitude low
    '{1'b0,1'b0,1'b0,4'd4, 4'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}, // R1 no carrier
    '{1'b0,1'b0,1'b0,4'd4, 4'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1}, // R1 self-test on
    '{1'b0,1'b0,1'b0,4'd4, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1}, // R1 halted
    '{1'b0,1'b0,1'b0,4'd4, 4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}  // R1 all good
  };

  initial begin
    #(CLK_PERIOD * 195000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int errs;
    rst_n = 1'b0; line_b_sel = 1'b0; loop_en = 1'b0;
    spd_sel = 1'b0; rng_sel = 1'b0; fifo_bypass = 1'b0;
    amp_ok = 1'b1; carrier_ok = 1'b1; bist_on = 1'b0; tx_halt = 1'b0;
    wait_cyc(5);
    // R11 reset state
    check(link_fault == 1'b1, "R11", "fault in reset", link_fault, 1);
    check(path_sel == 2'b00, "R11", "code in reset", path_sel, 0);
    rst_n = 1'b1;
    wait_cyc(500);
    check(link_fault == 1'b1, "R11", "fault before first window", link_fault, 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      spd_sel = VEC[i].spd; rng_sel = VEC[i].rng; fifo_bypass = VEC[i].byp;
      g_gap = int'(VEC[i].gap); g_k = int'(VEC[i].k); g_dn = VEC[i].dn;
      amp_ok = VEC[i].amp; carrier_ok = VEC[i].car;
      bist_on = VEC[i].bist; tx_halt = VEC[i].halt;
      wait_cyc(2 * WIN * (int'(VEC[i].gap) + 1) + 100);
      check(link_fault == VEC[i].fault, $sformatf("vector %0d", i), "fault",
            link_fault, VEC[i].fault);
    end

    // R5 selection codes
    line_b_sel = 1'b1; wait_cyc(1);
    check(path_sel == 2'b01, "R5", "line B code", path_sel, 1);
    loop_en = 1'b1; wait_cyc(1);
    check(path_sel == 2'b10, "R5", "loop overrides B", path_sel, 2);
    line_b_sel = 1'b0; wait_cyc(1);
    check(path_sel == 2'b10, "R5", "loop with A", path_sel, 2);
    loop_en = 1'b0; wait_cyc(1);
    check(path_sel == 2'b00, "R5", "line A code", path_sel, 0);
    wait_cyc(2600);
    check(link_fault == 1'b0, "R7", "settled before switch", link_fault, 0);

    // R7 switch forces fault for a window
    line_b_sel = 1'b1;
    wait_cyc(500);
    check(link_fault == 1'b1, "R7", "fault mid window after switch", link_fault, 1);
    wait_cyc(1100);
    check(link_fault == 1'b0, "R7", "clear after full window", link_fault, 0);

    // R8 reference stall
    ref_stall = 1'b1;
    wait_cyc(1100);
    check(link_fault == 1'b1, "R8", "fault on stalled reference", link_fault, 1);
    ref_stall = 1'b0;
    wait_cyc(2600);
    check(link_fault == 1'b0, "R8", "recovery after stall", link_fault, 0);

    // R6 run length
    bit_run = 5; wait_cyc(10);
    errs = 0;
    for (int c = 0; c < 100; c++) begin
      wait_cyc(1);
      if (link_fault) errs++;
    end
    check(errs == 0, "R6", "runs of MAX_RUN faulting cycles", errs, 0);
    bit_run = 0; wait_cyc(20);
    check(link_fault == 1'b1, "R6", "constant bits", link_fault, 1);
    bit_run = 1; wait_cyc(5);
    check(link_fault == 1'b0, "R6", "recover on transitions", link_fault, 0);

    // R10 / R9 stopped clock and synchronizer latency
    clk_run = 1'b0;
    amp_ok = 1'b0;
    #(CLK_PERIOD * 20);
    check(link_fault == 1'b0, "R10", "hold while clock stopped", link_fault, 0);
    clk_run = 1'b1;
    wait_cyc(2);
    check(link_fault == 1'b0, "R9", "after two edges", link_fault, 0);
    wait_cyc(1);
    check(link_fault == 1'b1, "R9", "after third edge", link_fault, 1);
    amp_ok = 1'b1;
    wait_cyc(5);
    check(link_fault == 1'b0, "R9", "status restored", link_fault, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule